// File: doc/BRIEF.md
# Register File with Two Write Ports and One Read Port

This block stores a small set of equal-width registers. Two independent write ports can each update one register on the same rising clock edge. A single read port returns one register's contents. Each write port has its own register select, data bus and enable. The read port takes a register select and returns that register's contents combinationally, with no clock involved.

Each write port's select is decoded into a one-hot hit vector, which that port's enable gates. Every register slot loads when either port hits it. A per-slot 2:1 choice feeds the slot's data input. That choice takes port 1's data whenever port 1 hits the slot and port 0's data otherwise. As a result, port 1 wins when both ports name the same register.

There is no forwarding path from write to read. A register being written shows its old value on the read output until the clock edge that commits the write. A synchronous active-high reset clears every register to zero.

Top module: `dwrf_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, every register becomes zero, whatever the write inputs are.
- R2: When `wr0_en` is high and port 1 does not hit the same register, the register numbered `wr0_sel` holds `wr0_data` after the rising edge.
- R3: When `wr1_en` is high, the register numbered `wr1_sel` holds `wr1_data` after the rising edge.
- R4: When both enables are high and the two selects differ, both registers are updated on the same edge.
- R5: When both enables are high and `wr0_sel` equals `wr1_sel`, that register stores `wr1_data`.
- R6: When both enables are low, no register changes, whatever the selects and data are.
- R7: `rd_data` equals the contents of the register numbered `rd_sel`, and it follows a change of `rd_sel` within the same cycle, with no clock edge needed.
- R8: While a register is being written and read in the same cycle, `rd_data` shows the value stored before the edge. The new value appears only after the committing edge.
- R9: A write changes only the register or registers its ports select. Every other register keeps its value.
- R10: A port whose enable is low has no effect, even when its select names the register the other port writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr0_en | input | 1 | Write enable of port 0 |
| wr0_sel | input | SEL_W | Register number written by port 0 |
| wr0_data | input | DATA_W | Data written by port 0 |
| wr1_en | input | 1 | Write enable of port 1 (wins on a collision) |
| wr1_sel | input | SEL_W | Register number written by port 1 |
| wr1_data | input | DATA_W | Data written by port 1 |
| rd_sel | input | SEL_W | Register number to read |
| rd_data | output | DATA_W | Combinational contents of the selected register |

## Verification
The bench builds the block with its defaults: eight registers of eight bits, with 3-bit selects. At this size every register index, including the highest one, can be named directly from the vector table. After each step the bench sweeps all eight registers through `rd_sel` and compares them with its own model. This makes the whole file observable, so a stray write to a neighbouring slot or a lost collision is visible at once. Directed steps cover the same-cycle read of a register under write and a reset asserted while both ports are writing.

// File: rtl/dwrf_pkg.sv
`timescale 1ns/100ps
package dwrf_pkg;

    localparam int unsigned DEF_NUM_REGS = 8;
    localparam int unsigned DEF_DATA_W   = 8;

    // Which write port feeds a register slot's data input
    typedef enum logic {
        SRC_PORT0 = 1'b0,
        SRC_PORT1 = 1'b1
    } wsrc_e;

    // Port 1 takes the slot whenever it hits it; otherwise port 0 data is offered
    function automatic wsrc_e pick_src(input logic hit_p1);
        return hit_p1 ? SRC_PORT1 : SRC_PORT0;
    endfunction

endpackage

// File: rtl/dwrf_wr_decode.sv
`timescale 1ns/100ps
module dwrf_wr_decode #(
    parameter int unsigned NUM_REGS = dwrf_pkg::DEF_NUM_REGS,
    localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
    input  logic                en,
    input  logic [SEL_W-1:0]    sel,
    output logic [NUM_REGS-1:0] hit
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = en && (sel == SEL_W'(g));
    end

    always_comb begin
        AST_DECODE_SINGLE: assert ($onehot0(hit)); // R9
        if (!en) begin
            AST_DECODE_IDLE: assert (hit == '0); // R6
        end
    end

endmodule

// File: rtl/dwrf_slot.sv
`timescale 1ns/100ps
module dwrf_slot
    import dwrf_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit0,
    input  logic              hit1,
    input  logic [DATA_W-1:0] wdata0,
    input  logic [DATA_W-1:0] wdata1,
    output logic [DATA_W-1:0] q
);

    wsrc_e             src;
    logic              load;
    logic [DATA_W-1:0] next_val;

    always_comb begin
        load     = hit0 | hit1;
        src      = pick_src(hit1);
        next_val = (src == SRC_PORT1) ? wdata1 : wdata0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= next_val;
        end
    end

    AST_SLOT_CLEAR: assert property (@(posedge clk)
        rst |=> (q == '0)); // R1
    AST_SLOT_PORT0_LOAD: assert property (@(posedge clk) disable iff (rst)
        (hit0 && !hit1) |=> (q == $past(wdata0))); // R2
    AST_SLOT_PORT1_WINS: assert property (@(posedge clk) disable iff (rst)
        hit1 |=> (q == $past(wdata1))); // R5
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!hit0 && !hit1) |=> $stable(q)); // R6

endmodule

// File: rtl/dwrf_rd_mux.sv
`timescale 1ns/100ps
module dwrf_rd_mux #(
    parameter int unsigned NUM_REGS = dwrf_pkg::DEF_NUM_REGS,
    parameter int unsigned DATA_W   = dwrf_pkg::DEF_DATA_W,
    localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [SEL_W-1:0]                sel,
    output logic [DATA_W-1:0]               dout
);

    always_comb begin
        dout = regs[sel];
    end

endmodule

// File: rtl/dwrf_top.sv
`timescale 1ns/100ps
module dwrf_top #(
    parameter int unsigned NUM_REGS = dwrf_pkg::DEF_NUM_REGS,
    parameter int unsigned DATA_W   = dwrf_pkg::DEF_DATA_W,
    localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr0_en,
    input  logic [SEL_W-1:0]  wr0_sel,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [SEL_W-1:0]  wr1_sel,
    input  logic [DATA_W-1:0] wr1_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_REGS-1:0]             hit_p0;
    logic [NUM_REGS-1:0]             hit_p1;
    logic [NUM_REGS-1:0][DATA_W-1:0] store;

    dwrf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec0 (
        .en  (wr0_en),
        .sel (wr0_sel),
        .hit (hit_p0)
    );

    dwrf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec1 (
        .en  (wr1_en),
        .sel (wr1_sel),
        .hit (hit_p1)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        dwrf_slot #(.DATA_W(DATA_W)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .hit0   (hit_p0[g]),
            .hit1   (hit_p1[g]),
            .wdata0 (wr0_data),
            .wdata1 (wr1_data),
            .q      (store[g])
        );
    end

    dwrf_rd_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
        .regs (store),
        .sel  (rd_sel),
        .dout (rd_data)
    );

    AST_COLLIDE_PORT1: assert property (@(posedge clk) disable iff (rst)
        (wr0_en && wr1_en && (wr0_sel == wr1_sel))
        |=> (store[$past(wr1_sel)] == $past(wr1_data))); // R5
    AST_DUAL_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (wr0_en && wr1_en && (wr0_sel != wr1_sel))
        |=> (store[$past(wr0_sel)] == $past(wr0_data))); // R4
    AST_IDLE_FILE: assert property (@(posedge clk) disable iff (rst)
        (!wr0_en && !wr1_en) |=> $stable(store)); // R6
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ($stable(rd_sel) && !$past(rst) && !$past(wr0_en) && !$past(wr1_en))
        |-> $stable(rd_data)); // R7

endmodule

// File: tb/dwrf_top_tb_top.sv
`timescale 1ns/100ps
module dwrf_top_tb_top;

    localparam int NREG = 8;
    localparam int DW   = 8;
    localparam int SW   = 3;

    typedef struct packed {
        logic          w0;
        logic [SW-1:0] s0;
        logic [DW-1:0] d0;
        logic          w1;
        logic [SW-1:0] s1;
        logic [DW-1:0] d1;
        logic [SW-1:0] rs;
        logic [DW-1:0] exp;
    } vec_t;

    // Expected read values hand-derived from R2..R10, file cleared before the walk
    localparam vec_t VECS [12] = '{
        '{1'b1, 3'd0, 8'h11, 1'b0, 3'd0, 8'h00, 3'd0, 8'h11}, // R2
        '{1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 8'h22, 3'd1, 8'h22}, // R3
        '{1'b1, 3'd2, 8'h33, 1'b1, 3'd3, 8'h44, 3'd2, 8'h33}, // R4
        '{1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 8'h00, 3'd3, 8'h44}, // R4 R6
        '{1'b1, 3'd5, 8'h55, 1'b1, 3'd5, 8'h66, 3'd5, 8'h66}, // R5
        '{1'b1, 3'd6, 8'h77, 1'b0, 3'd6, 8'h88, 3'd6, 8'h77}, // R10
        '{1'b0, 3'd7, 8'h99, 1'b0, 3'd7, 8'hAA, 3'd7, 8'h00}, // R6
        '{1'b1, 3'd7, 8'hBB, 1'b0, 3'd0, 8'hCC, 3'd0, 8'h11}, // R10 R9
        '{1'b1, 3'd4, 8'hDD, 1'b1, 3'd4, 8'hEE, 3'd4, 8'hEE}, // R5
        '{1'b1, 3'd0, 8'hF0, 1'b1, 3'd7, 8'h0F, 3'd7, 8'h0F}, // R3
        '{1'b0, 3'd3, 8'h12, 1'b0, 3'd2, 8'h34, 3'd0, 8'hF0}, // R6
        '{1'b1, 3'd1, 8'hA5, 1'b1, 3'd2, 8'h5A, 3'd1, 8'hA5}  // R4
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          wr0_en, wr1_en;
    logic [SW-1:0] wr0_sel, wr1_sel, rd_sel;
    logic [DW-1:0] wr0_data, wr1_data, rd_data;

    logic [DW-1:0] model [NREG];
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;

    always #2 clk = ~clk;

    dwrf_top #(.NUM_REGS(NREG), .DATA_W(DW)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr0_en   (wr0_en),
        .wr0_sel  (wr0_sel),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_sel  (wr1_sel),
        .wr1_data (wr1_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reads every register through rd_sel and compares with the model (R7 R9)
    task automatic sweep(input string req);
        for (int i = 0; i < NREG; i++) begin
            rd_sel = SW'(i);
            #0.1;
            check(req, rd_data, model[i]);
        end
    endtask

    task automatic idle_inputs();
        wr0_en = 1'b0; wr1_en = 1'b0;
        wr0_sel = '0;  wr1_sel = '0;
        wr0_data = '0; wr1_data = '0;
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        wr0_en = v.w0; wr0_sel = v.s0; wr0_data = v.d0;
        wr1_en = v.w1; wr1_sel = v.s1; wr1_data = v.d1;
        rd_sel = v.rs;
        @(posedge clk);
        if (v.w0) model[v.s0] = v.d0;
        if (v.w1) model[v.s1] = v.d1;
        #0.5;
        idle_inputs();
        #0.1;
        check("R2-R6/R10 table", rd_data, v.exp);
        sweep("R9 sweep");
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        rd_sel = '0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        sweep("R1 reset state");

        foreach (VECS[k]) apply(VECS[k]);

        // R8: read of the register under write shows the old value until the edge
        @(negedge clk);
        wr0_en = 1'b1; wr0_sel = 3'd3; wr0_data = 8'h6C;
        rd_sel = 3'd3;
        #0.5;
        check("R8 before edge", rd_data, model[3]);
        @(posedge clk);
        model[3] = 8'h6C;
        #0.5;
        idle_inputs();
        #0.1;
        check("R8 after edge", rd_data, 8'h6C);

        // R7: rd_data follows rd_sel with no clock edge in between
        @(negedge clk);
        rd_sel = 3'd5;
        #0.2;
        check("R7 mux 5", rd_data, model[5]);
        rd_sel = 3'd4;
        #0.2;
        check("R7 mux 4", rd_data, model[4]);

        // R1: reset wins over both ports writing
        @(negedge clk);
        rst = 1'b1;
        wr0_en = 1'b1; wr0_sel = 3'd2; wr0_data = 8'hC3;
        wr1_en = 1'b1; wr1_sel = 3'd6; wr1_data = 8'h3C;
        @(posedge clk);
        for (int i = 0; i < NREG; i++) model[i] = '0;
        #0.5;
        idle_inputs();
        @(negedge clk);
        rst = 1'b0;
        sweep("R1 mid-run clear");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule